// File: doc/BRIEF.md
# Line Error Counter Bank with Merged Interrupt

This block keeps four 16-bit event counters for a line monitor: line code violations (index 0), framing errors (index 1), parity errors (index 2) and path disagreements (index 3). Each counter advances by one for every clock cycle in which its single-cycle error strobe is high. The error detectors that raise the strobes sit outside the block.

Every counter can stop at full scale and latch a sticky interrupt bit. The line code violation and framing counters can instead run freely. A free-running counter rolls over and gives a one-cycle carry pulse, so that wider counts can be kept outside the block. A single mode input selects free-running for those two counters. The parity and disagreement counters always saturate. Each sticky bit has an enable, and the enabled bits are ORed onto one shared interrupt line.

A host reads a counter by raising a read strobe with a counter index. In the same cycle the block returns the count, then clears the count and that counter's sticky bit.

Top module: `err_cnt_bank`

## Requirements
- R1: A high strobe on `err_i[k]` for one cycle raises counter k by exactly one at the next edge and leaves the other counters unchanged (index 0 LCV, 1 frame, 2 parity, 3 disagreement).
- R2: In saturating mode, a counter that holds 0xFFFF stays at 0xFFFF when further errors arrive.
- R3: In saturating mode, an error that finds its counter at 0xFFFE or 0xFFFF sets that counter's sticky interrupt bit at the same edge.
- R4: With `free_run_i` high, counters 0 and 1 roll over from 0xFFFF to 0x0000 on an error. `carry_o[k]` is high for exactly the one cycle after that edge, and no sticky bit is set in this mode.
- R5: Counters 2 and 3 saturate whatever the value of `free_run_i`, and `carry_o[3:2]` stays 0.
- R6: `rd_data_o` shows the count of the counter chosen by `rd_sel_i` in the current cycle. A cycle with `rd_en_i` high clears that counter at the edge that ends the cycle.
- R7: An error on the counter being read in the same cycle leaves the count at 1 after the read, not 0.
- R8: A read clears the sticky interrupt bit of the counter that was read.
- R9: `irq_o` is the OR over k of sticky bit k AND `int_en_i[k]`. A sticky bit whose enable is low does not drive `irq_o`, but it stays latched, and `irq_o` rises as soon as that enable goes high.
- R10: After reset, all counts read 0 and `carry_o` and `irq_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| err_i | input | 4 | Single-cycle error strobes, one per counter |
| free_run_i | input | 1 | 1: counters 0 and 1 wrap and emit a carry; 0: all saturate |
| int_en_i | input | 4 | Per-counter interrupt enables |
| rd_en_i | input | 1 | Host read strobe; clears the selected counter |
| rd_sel_i | input | 2 | Index of the counter to read |
| rd_data_o | output | 16 | Count of the selected counter |
| carry_o | output | 4 | One-cycle rollover pulses (bits 3:2 always 0) |
| irq_o | output | 1 | Shared interrupt: OR of enabled sticky bits |

## Verification
The hardest situation to reach from the ports is full scale: a counter only gets there after 65535 error strobes with no read in between. The stimulus raises all four strobes together for 65535 cycles with the interrupt enables low. It then checks saturation, the gated and later enabled interrupt, and the clearing of the sticky bits on a read. Next it switches to free-running mode while counters 0 and 1 still hold 0xFFFF, so that a single further error shows the rollover and the carry pulse. A seeded random phase mixes reads, same-cycle errors, enable changes and mode changes at small counts.

// File: rtl/err_cnt_pkg.sv
// Package err_cnt_pkg
// Shared indices and widths for the error counter bank.
// Assumes exactly four counters, in the fixed order below.
package err_cnt_pkg;
    localparam int NUM_CNT = 4;
    localparam int SEL_W   = $clog2(NUM_CNT);

    typedef enum logic [SEL_W-1:0] {
        IDX_LCV  = 2'd0,
        IDX_FRM  = 2'd1,
        IDX_PAR  = 2'd2,
        IDX_DGR  = 2'd3
    } cnt_idx_e;

    // Counters that may run freely (bit per index): LCV and frame only.
    localparam logic [NUM_CNT-1:0] WRAP_CAPABLE = 4'b0011;
endpackage

// File: rtl/err_cnt_cell.sv
// Module err_cnt_cell
// One error counter. In saturating mode it holds at all ones and latches
// a sticky flag. In wrap mode (only when CAN_WRAP) it rolls over and
// pulses carry_o for one cycle. A clear from the read port takes priority;
// an error during the clear leaves a count of one.
// Assumes err_i and rd_clr_i are synchronous to clk.
module err_cnt_cell #(
    parameter int   CNT_W    = 16,
    parameter logic CAN_WRAP = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             err_i,
    input  logic             rd_clr_i,
    input  logic             free_run_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             sticky_o,
    output logic             carry_o
);
    localparam logic [CNT_W-1:0] FULL      = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] NEAR_FULL = {{(CNT_W-1){1'b1}}, 1'b0};
    localparam logic [CNT_W-1:0] ONE_LOAD  = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_q;
    logic             sticky_q;
    logic             carry_q;
    logic             wrap_mode;
    logic             at_full;

    // Mode gate: only a wrap-capable counter honours free running.
    assign wrap_mode = CAN_WRAP & free_run_i;
    assign at_full   = (cnt_q == FULL);

    // Count update: read clear first, then saturate or wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (rd_clr_i) begin
            cnt_q <= err_i ? ONE_LOAD : '0;
        end else if (err_i) begin
            if (!(at_full && !wrap_mode)) begin
                cnt_q <= cnt_q + ONE_LOAD;
            end
        end
    end

    // Carry pulse on the wrapping increment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            carry_q <= 1'b0;
        end else begin
            carry_q <= err_i && !rd_clr_i && at_full && wrap_mode;
        end
    end

    // Sticky interrupt: set on reaching/being at full scale in saturating mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sticky_q <= 1'b0;
        end else if (rd_clr_i) begin
            sticky_q <= 1'b0;
        end else if (err_i && !wrap_mode && (at_full || cnt_q == NEAR_FULL)) begin
            sticky_q <= 1'b1;
        end
    end

    assign cnt_o    = cnt_q;
    assign sticky_o = sticky_q;
    assign carry_o  = carry_q;

    // R2
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wrap_mode && at_full && !rd_clr_i) |=> (cnt_q == FULL));

    // R3
    sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wrap_mode && err_i && !rd_clr_i && cnt_q == NEAR_FULL) |=> sticky_q);

    // R4
    carry_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        carry_q |-> (cnt_q == '0 && $past(cnt_q) == FULL));

    // R5
    carry_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        carry_q |-> (CAN_WRAP == 1'b1));

    // R7
    rd_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_clr_i |=> (cnt_q == (err_i ? ONE_LOAD : '0)) || (cnt_q == {{(CNT_W-1){1'b0}}, $past(err_i)}));

    // R8
    sticky_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_clr_i |=> !sticky_q);
endmodule

// File: rtl/err_rd_port.sv
// Module err_rd_port
// Host read path: selects the addressed count and decodes a one-hot
// clear for the counter being read.
// Assumes rd_sel_i is below N.
module err_rd_port #(
    parameter int N     = 4,
    parameter int CNT_W = 16,
    parameter int SEL_W = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     rd_en_i,
    input  logic [SEL_W-1:0]         rd_sel_i,
    input  logic [N-1:0][CNT_W-1:0]  cnt_i,
    output logic [CNT_W-1:0]         rd_data_o,
    output logic [N-1:0]             clr_o
);
    // Count selection for the host.
    always_comb begin
        rd_data_o = cnt_i[rd_sel_i];
    end

    // One-hot clear decode, one bit per counter.
    for (genvar k = 0; k < N; k++) begin : g_clr
        assign clr_o[k] = rd_en_i && (rd_sel_i == SEL_W'(k));
    end

    // R6
    clr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(clr_o));

    // R6
    clr_needs_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr_o) |-> rd_en_i);
endmodule

// File: rtl/err_irq_merge.sv
// Module err_irq_merge
// Gates each sticky bit with its enable and ORs the result onto one line.
// Assumes the sticky bits are registered upstream.
module err_irq_merge #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] sticky_i,
    input  logic [N-1:0] en_i,
    output logic         irq_o
);
    logic [N-1:0] gated;

    // Per-source gating.
    assign gated = sticky_i & en_i;
    // Shared line.
    assign irq_o = |gated;

    // R9
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (|en_i));
endmodule

// File: rtl/err_cnt_bank.sv
// Module err_cnt_bank
// Top of the error counter bank: four counters, a read/clear port and
// a merged interrupt line. free_run_i applies to wrap-capable counters.
// Assumes synchronous active-low reset and single-cycle error strobes.
module err_cnt_bank #(
    parameter int CNT_W = 16
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [err_cnt_pkg::NUM_CNT-1:0]     err_i,
    input  logic                                free_run_i,
    input  logic [err_cnt_pkg::NUM_CNT-1:0]     int_en_i,
    input  logic                                rd_en_i,
    input  logic [err_cnt_pkg::SEL_W-1:0]       rd_sel_i,
    output logic [CNT_W-1:0]                    rd_data_o,
    output logic [err_cnt_pkg::NUM_CNT-1:0]     carry_o,
    output logic                                irq_o
);
    import err_cnt_pkg::*;

    logic [NUM_CNT-1:0][CNT_W-1:0] cnt_w;
    logic [NUM_CNT-1:0]            sticky_w;
    logic [NUM_CNT-1:0]            clr_w;

    // Counter instances; the wrap variant is chosen per index.
    for (genvar k = 0; k < NUM_CNT; k++) begin : g_cell
        err_cnt_cell #(
            .CNT_W    (CNT_W),
            .CAN_WRAP (WRAP_CAPABLE[k])
        ) u_cell (
            .clk        (clk),
            .rst_n      (rst_n),
            .err_i      (err_i[k]),
            .rd_clr_i   (clr_w[k]),
            .free_run_i (free_run_i),
            .cnt_o      (cnt_w[k]),
            .sticky_o   (sticky_w[k]),
            .carry_o    (carry_o[k])
        );
    end

    err_rd_port #(
        .N     (NUM_CNT),
        .CNT_W (CNT_W),
        .SEL_W (SEL_W)
    ) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en_i   (rd_en_i),
        .rd_sel_i  (rd_sel_i),
        .cnt_i     (cnt_w),
        .rd_data_o (rd_data_o),
        .clr_o     (clr_w)
    );

    err_irq_merge #(
        .N (NUM_CNT)
    ) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .sticky_i (sticky_w),
        .en_i     (int_en_i),
        .irq_o    (irq_o)
    );

    // R5
    no_carry_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (carry_o & ~WRAP_CAPABLE) == '0);

    // R1
    single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!err_i[0] && !clr_w[0]) |=> $stable(cnt_w[0]));
endmodule

// File: tb/tb_err_cnt_bank.sv
// Bench for err_cnt_bank: seeded random plus directed full-scale cases,
// compared against a model built from the requirements.
module tb_err_cnt_bank;
    localparam int W = 16;
    localparam logic [W-1:0] FULL = 16'hFFFF;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] err_i;
    logic       free_run_i;
    logic [3:0] int_en_i;
    logic       rd_en_i;
    logic [1:0] rd_sel_i;
    logic [W-1:0] rd_data_o;
    logic [3:0] carry_o;
    logic       irq_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [W-1:0] m_cnt [4];
    logic [3:0]   m_sticky;
    logic [3:0]   m_carry;

    always #2.5 clk = ~clk;

    err_cnt_bank #(.CNT_W(W)) dut (
        .clk(clk), .rst_n(rst_n), .err_i(err_i), .free_run_i(free_run_i),
        .int_en_i(int_en_i), .rd_en_i(rd_en_i), .rd_sel_i(rd_sel_i),
        .rd_data_o(rd_data_o), .carry_o(carry_o), .irq_o(irq_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic wrap_of(input int k, input logic fr);
        return (k < 2) && fr;
    endfunction

    function automatic logic [W-1:0] next_cnt(input logic [W-1:0] c, input logic e,
                                              input logic clr, input logic wr);
        if (clr) return e ? 16'd1 : 16'd0;
        if (!e) return c;
        if (c == FULL && !wr) return c;
        return c + 16'd1;
    endfunction

    // One clock: drive, check read data, advance model, check outputs.
    task automatic tick(input logic [3:0] e, input logic rd, input logic [1:0] s, input string req);
        logic [3:0] clr;
        @(negedge clk);
        err_i = e; rd_en_i = rd; rd_sel_i = s;
        #1;
        check({req, " R6 rd_data"}, 32'(rd_data_o), 32'(m_cnt[s]));
        for (int k = 0; k < 4; k++) begin
            clr[k] = rd && (s == 2'(k));
            m_carry[k] = !clr[k] && e[k] && m_cnt[k] == FULL && wrap_of(k, free_run_i);
            if (clr[k]) m_sticky[k] = 1'b0;
            else if (e[k] && !wrap_of(k, free_run_i) && m_cnt[k] >= FULL - 16'd1) m_sticky[k] = 1'b1;
            m_cnt[k] = next_cnt(m_cnt[k], e[k], clr[k], wrap_of(k, free_run_i));
        end
        @(posedge clk);
        #1;
        check({req, " R4 carry"}, 32'(carry_o), 32'(m_carry));
        check({req, " R9 irq"}, 32'(irq_o), 32'(|(m_sticky & int_en_i)));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed;
        seed = $urandom(32'h5EED1234);
        rst_n = 1'b0; err_i = '0; free_run_i = 1'b0; int_en_i = '0;
        rd_en_i = 1'b0; rd_sel_i = '0;
        for (int k = 0; k < 4; k++) m_cnt[k] = '0;
        m_sticky = '0; m_carry = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        // R10 reset state
        check("R10 carry", 32'(carry_o), 0);
        check("R10 irq", 32'(irq_o), 0);
        for (int k = 0; k < 4; k++) tick(4'b0, 1'b1, 2'(k), "R10");

        // R1 directed: parity counter only
        int_en_i = 4'hF;
        repeat (3) tick(4'b0100, 1'b0, 2'd0, "R1");
        for (int k = 0; k < 4; k++) tick(4'b0, 1'b0, 2'(k), "R1");
        tick(4'b0, 1'b1, 2'd2, "R1");

        // R7 error during read
        tick(4'b0001, 1'b0, 2'd0, "R7");
        tick(4'b0001, 1'b1, 2'd0, "R7");
        tick(4'b0000, 1'b0, 2'd0, "R7");

        // Random phase (R1, R6, R7, R9)
        for (int i = 0; i < 3000; i++) begin
            int_en_i   = 4'($urandom);
            free_run_i = 1'($urandom);
            tick(4'($urandom), ($urandom % 4) == 0, 2'($urandom), "R1");
        end

        // Clear everything
        free_run_i = 1'b0;
        for (int k = 0; k < 4; k++) tick(4'b0, 1'b1, 2'(k), "R6");

        // Full-scale hammer with interrupts masked (R2, R3, R9)
        int_en_i = 4'h0;
        for (int i = 0; i < 65535; i++) tick(4'hF, 1'b0, 2'd3, "R2");
        repeat (5) tick(4'hF, 1'b0, 2'd1, "R2");
        check("R2 sat value", 32'(m_cnt[3]), 32'(FULL));
        int_en_i = 4'b0001;
        tick(4'h0, 1'b0, 2'd0, "R9");
        check("R3 irq after enable", 32'(irq_o), 1);
        // R8 read clears parity sticky
        int_en_i = 4'b0100;
        tick(4'h0, 1'b1, 2'd2, "R8");
        check("R8 irq cleared", 32'(irq_o), 0);

        // R4/R5 rollover at full scale in free-running mode
        free_run_i = 1'b1;
        int_en_i = 4'b1000;
        tick(4'hF, 1'b0, 2'd0, "R4");
        check("R4 carry pulse", 32'(carry_o), 32'(4'b0011));
        tick(4'h0, 1'b0, 2'd0, "R4");
        check("R4 carry single", 32'(carry_o), 0);
        tick(4'h0, 1'b0, 2'd3, "R5");
        check("R5 still full", 32'(rd_data_o), 32'(FULL));
        tick(4'h0, 1'b1, 2'd1, "R4");
        tick(4'h0, 1'b0, 2'd2, "R5");

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule